// File: doc/BRIEF.md
# Video Packet Stream Cleaner

This block sits inline on a packetised video stream in which every frame travels as one data packet and is announced by a control packet that states the frame width and height. The first beat of every packet is a header whose low nibble names the packet type. The cleaner learns the declared frame size from each complete control packet. It then counts the pixel beats that each following video data packet delivers. A video packet that stops short, for instance because a source was unplugged mid-frame, has its end-of-packet marker held back. The cleaner then closes the frame with mid-grey beats until the declared beat count is met. A video packet that runs long is cut at the declared size, and its surplus beats are discarded.

Each beat carries two pixels of three 10-bit symbols, 60 bits in all. Both sides use a valid/ready handshake with start- and end-of-packet flags. Forwarded beats pass combinationally with no added latency. While inserting grey beats the block drives the output itself and holds its source stalled. The control machine has six states. ST_IDLE waits for a header. ST_CTRL takes the size beat of a control packet. ST_PASS forwards a packet untouched. ST_VIDEO counts pixel beats. ST_PAD inserts grey beats. ST_DROP swallows surplus beats.

The transitions are these:
- idle→ctrl on a control header; idle→video on a video header when a size is known and nonzero.
- idle→pad on a one-beat video packet; idle→drop on a zero-size frame with a body.
- idle→pass on other headers, or on a video header with no size known.
- ctrl→pass, or ctrl→idle if the size beat ends the packet; pass→idle on end-of-packet.
- video→pad on an early end; video→drop on a full count without end; video→idle on a full count with end.
- pad→idle on the last grey beat; drop→idle on the input end-of-packet.

Top module: `stc_stream_cleaner`

## Requirements
- R1: A header is a beat with start-of-packet set; its bits [3:0] give the type: 4'h0 is video data, 4'hF is control, any other value is forwarded unchanged through its end-of-packet.
- R2: The beat after a control header holds width in bits [15:0] and height in bits [31:16]. The declared frame is ceil(width/2)*height beats. A control packet that ends on its header leaves the previous size in force. Control packets are forwarded unchanged.
- R3: In a video packet of correct length, the header and every pixel beat pass unchanged, and end-of-packet appears on the last pixel beat.
- R4: A video packet that ends before the declared count has its end-of-packet withheld. Grey beats, with every 10-bit symbol equal to 512, follow until the count is met, and end-of-packet is set only on the final beat.
- R5: While grey beats are inserted, ready towards the source is low and output valid is high. A grey beat that is not accepted stays unchanged on the output.
- R6: Pixel beats beyond the declared count are discarded, and end-of-packet is forced on the last in-size beat.
- R7: When the declared count is zero, the video header carries end-of-packet and all body beats are discarded.
- R8: A video packet arriving before any complete control packet is forwarded unchanged and sets err_no_ctrl, which stays set until reset.
- R9: After reset, output valid and err_no_ctrl are low and no frame size is known.
- R10: Every video packet leaving the block has exactly one start-of-packet (its header) and exactly one end-of-packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Block accepts the upstream beat |
| in_data | input | 60 | Upstream beat payload |
| in_sop | input | 1 | Upstream start of packet |
| in_eop | input | 1 | Upstream end of packet |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 60 | Downstream beat payload |
| out_sop | output | 1 | Downstream start of packet |
| out_eop | output | 1 | Downstream end of packet |
| err_no_ctrl | output | 1 | Sticky: video seen before any frame size |

## Verification
The counting path is tried in five ways, and each shows a different case. Exact-length frames show that nothing is added. Short frames, including one with only a header, show where the grey fill starts and ends. Long frames show truncation and where end-of-packet is forced. A frame width that is not a multiple of two shows the rounding in the declared count. Zero-size, header-only control, foreign-type and size-less packets separate the forwarding paths from the counting path. A run with a toggling downstream ready shows that grey insertion respects back-pressure and keeps the source stalled.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_PASS,
        ST_VIDEO,
        ST_PAD,
        ST_DROP
    } stc_state_e;

    localparam logic [3:0] TYPE_VIDEO = 4'h0;
    localparam logic [3:0] TYPE_CTRL  = 4'hF;

endpackage

// File: rtl/stc_hdr_decode.sv
module stc_hdr_decode #(
    parameter int DIM_W        = 16,
    parameter int PIX_PER_BEAT = 2,
    parameter int CNT_W        = 2 * DIM_W
) (
    input  logic [2*DIM_W-1:0] low_bits,
    output logic               is_video,
    output logic               is_ctrl,
    output logic [CNT_W-1:0]   decl_beats
);
    import stc_pkg::*;

    logic [DIM_W-1:0] width_px;
    logic [DIM_W-1:0] height_ln;
    logic [CNT_W-1:0] beats_per_line;

    always_comb begin
        width_px       = low_bits[DIM_W-1:0];
        height_ln      = low_bits[2*DIM_W-1:DIM_W];
        is_video       = (low_bits[3:0] == TYPE_VIDEO);
        is_ctrl        = (low_bits[3:0] == TYPE_CTRL);
        // rounded-up beats per line, then times the line count
        beats_per_line = (CNT_W'(width_px) + CNT_W'(PIX_PER_BEAT - 1)) / CNT_W'(PIX_PER_BEAT);
        decl_beats     = beats_per_line * CNT_W'(height_ln);
    end

endmodule

// File: rtl/stc_size_reg.sv
module stc_size_reg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_beats,
    input  logic             set_err,
    output logic             have_size,
    output logic [CNT_W-1:0] target,
    output logic             err
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_size <= 1'b0;
            target    <= '0;
            err       <= 1'b0;
        end else begin
            if (load) begin
                have_size <= 1'b1;
                target    <= load_beats;
            end
            if (set_err) begin
                err <= 1'b1;
            end
        end
    end

    // R8: the error flag never clears outside reset
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R2: once a size is known it stays known
    assert_size_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        have_size |=> have_size);

endmodule

// File: rtl/stc_beat_counter.sv
module stc_beat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

    always_comb begin
        at_last = ((count + CNT_W'(1)) == target);
    end

endmodule

// File: rtl/stc_stream_cleaner.sv
module stc_stream_cleaner #(
    parameter int SYM_W        = 10,
    parameter int SYM_PER_PIX  = 3,
    parameter int PIX_PER_BEAT = 2,
    parameter int DIM_W        = 16
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      in_valid,
    output logic                                      in_ready,
    input  logic [SYM_W*SYM_PER_PIX*PIX_PER_BEAT-1:0] in_data,
    input  logic                                      in_sop,
    input  logic                                      in_eop,
    output logic                                      out_valid,
    input  logic                                      out_ready,
    output logic [SYM_W*SYM_PER_PIX*PIX_PER_BEAT-1:0] out_data,
    output logic                                      out_sop,
    output logic                                      out_eop,
    output logic                                      err_no_ctrl
);
    import stc_pkg::*;

    localparam int BEAT_W = SYM_W * SYM_PER_PIX * PIX_PER_BEAT;
    localparam int CNT_W  = 2 * DIM_W;
    localparam logic [SYM_W-1:0]  MID_SYM = {1'b1, {(SYM_W-1){1'b0}}};
    localparam logic [BEAT_W-1:0] GREY    = {(SYM_PER_PIX*PIX_PER_BEAT){MID_SYM}};

    stc_state_e       state, state_nx;
    logic             is_video, is_ctrl;
    logic [CNT_W-1:0] decl_beats;
    logic             have_size;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] count;
    logic             at_last;
    logic             load, set_err, cnt_clear, cnt_inc;
    logic             in_fire;

    stc_hdr_decode #(
        .DIM_W        (DIM_W),
        .PIX_PER_BEAT (PIX_PER_BEAT),
        .CNT_W        (CNT_W)
    ) u_dec (
        .low_bits   (in_data[2*DIM_W-1:0]),
        .is_video   (is_video),
        .is_ctrl    (is_ctrl),
        .decl_beats (decl_beats)
    );

    stc_size_reg #(
        .CNT_W (CNT_W)
    ) u_size (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_beats (decl_beats),
        .set_err    (set_err),
        .have_size  (have_size),
        .target     (target),
        .err        (err_no_ctrl)
    );

    stc_beat_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .inc     (cnt_inc),
        .target  (target),
        .count   (count),
        .at_last (at_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs and next state
    always_comb begin
        state_nx  = state;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        out_sop   = in_sop;
        out_eop   = in_eop;
        load      = 1'b0;
        set_err   = 1'b0;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        in_fire   = in_valid && out_ready;

        unique case (state)
            ST_IDLE: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                if (in_fire && in_sop) begin
                    if (is_video && have_size) begin
                        cnt_clear = 1'b1;
                        if (target == '0) begin
                            out_eop  = 1'b1;
                            state_nx = in_eop ? ST_IDLE : ST_DROP;
                        end else begin
                            out_eop  = 1'b0;
                            state_nx = in_eop ? ST_PAD : ST_VIDEO;
                        end
                    end else if (is_video) begin
                        set_err  = 1'b1;
                        state_nx = in_eop ? ST_IDLE : ST_PASS;
                    end else if (is_ctrl) begin
                        state_nx = in_eop ? ST_IDLE : ST_CTRL;
                    end else begin
                        state_nx = in_eop ? ST_IDLE : ST_PASS;
                    end
                end else if (in_valid && in_sop && is_video) begin
                    if (have_size && target == '0) begin
                        out_eop = 1'b1;
                    end else if (have_size) begin
                        out_eop = 1'b0;
                    end
                end
            end
            ST_CTRL: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                if (in_fire) begin
                    load     = 1'b1;
                    state_nx = in_eop ? ST_IDLE : ST_PASS;
                end
            end
            ST_PASS: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                if (in_fire && in_eop) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_VIDEO: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_eop   = at_last;
                if (in_fire) begin
                    cnt_inc = 1'b1;
                    if (at_last) begin
                        state_nx = in_eop ? ST_IDLE : ST_DROP;
                    end else if (in_eop) begin
                        state_nx = ST_PAD;
                    end
                end
            end
            ST_PAD: begin
                in_ready  = 1'b0;
                out_valid = 1'b1;
                out_data  = GREY;
                out_sop   = 1'b0;
                out_eop   = at_last;
                if (out_ready) begin
                    cnt_inc = 1'b1;
                    if (at_last) begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_DROP: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
                if (in_valid && in_eop) begin
                    state_nx = ST_IDLE;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // R4: while counting, the count never reaches the declared size
    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VIDEO || state == ST_PAD) |-> (count < target));

    // R5: a refused grey beat is presented again unchanged
    assert_pad_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD && !out_ready) |=>
            (out_valid && !in_ready && $stable(out_data) && $stable(out_eop)));

    // R4: accepted final grey beat returns the machine to idle
    assert_pad_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD && out_ready && out_eop) |=> (state == ST_IDLE));

    // R6: a full count without input end leads to discarding
    assert_trunc_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VIDEO && out_valid && out_ready && out_eop && !in_eop)
            |=> (state == ST_DROP));

    // R9: first cycle after reset shows an idle output
    assert_reset_quiet_R9: assert property (@(posedge clk)
        (!rst_n) |=> (!err_no_ctrl && state == ST_IDLE));

endmodule

// File: tb/tb_stc_stream_cleaner.sv
module tb_stc_stream_cleaner;

    localparam int T = 20;
    localparam logic [59:0] GREY = {6{10'd512}};
    localparam int NV = 6;
    // {width, height, pixel beats supplied, expected output beats, expected grey beats}
    localparam logic [79:0] VEC [0:NV-1] = '{
        {16'd4, 16'd2, 16'd4, 16'd5,  16'd0},
        {16'd4, 16'd2, 16'd1, 16'd5,  16'd3},
        {16'd6, 16'd1, 16'd5, 16'd4,  16'd0},
        {16'd3, 16'd2, 16'd2, 16'd5,  16'd2},
        {16'd8, 16'd3, 16'd0, 16'd13, 16'd12},
        {16'd2, 16'd1, 16'd1, 16'd2,  16'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, in_sop, in_eop;
    logic [59:0] in_data;
    logic        out_valid, out_ready, out_sop, out_eop;
    logic [59:0] out_data;
    logic        err_no_ctrl;

    int checks = 0;
    int errors = 0;
    int n_out, n_grey, n_eop, n_sop, eop_idx, bad_ready;
    logic [59:0] last_data;
    bit toggle_ready = 1'b0;

    always #(T/2) clk = ~clk;

    stc_stream_cleaner dut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
        .in_sop (in_sop), .in_eop (in_eop),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .out_sop (out_sop), .out_eop (out_eop),
        .err_no_ctrl (err_no_ctrl)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        n_out = 0; n_grey = 0; n_eop = 0; n_sop = 0; eop_idx = -1; bad_ready = 0;
    endtask

    task automatic tick(output bit acc);
        #5;
        if (out_valid && out_ready) begin
            if (out_eop) begin n_eop++; eop_idx = n_out; end
            if (out_sop) n_sop++;
            if (!out_sop && out_data == GREY) n_grey++;
            last_data = out_data;
            n_out++;
        end
        if (out_valid && !out_sop && out_data == GREY && in_ready) bad_ready++;
        acc = in_valid && in_ready;
        @(negedge clk);
        if (toggle_ready) out_ready = ~out_ready;
    endtask

    task automatic send(input logic [59:0] d, input bit s, input bit e);
        bit acc;
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        do tick(acc); while (!acc);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic flush(input int n);
        bit acc;
        for (int i = 0; i < n; i++) tick(acc);
    endtask

    task automatic send_ctrl(input logic [15:0] w, input logic [15:0] h);
        send(60'hF, 1'b1, 1'b0);
        send({28'h0, h, w}, 1'b0, 1'b1);
    endtask

    task automatic send_pkt(input logic [3:0] typ, input int n);
        send({56'h0, typ}, 1'b1, n == 0);
        for (int i = 0; i < n; i++)
            send({20'hABCDE, 40'(i + 1)}, 1'b0, i == n - 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        flush(3);
        rst_n = 1'b1;
        flush(1);
    endtask

    initial begin
        #(T * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
        out_ready = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        do_reset();
        // R9: reset state
        check(!out_valid, "R9 out_valid", out_valid, 0);
        check(!err_no_ctrl, "R9 err_no_ctrl", err_no_ctrl, 0);

        // R8: video before any control packet passes untouched
        clear_stats();
        send_pkt(4'h0, 2); flush(5);
        check(n_out == 3, "R8 beats", n_out, 3);
        check(last_data == {20'hABCDE, 40'd2}, "R8 data", last_data[39:0], 2);
        check(err_no_ctrl, "R8 err set", err_no_ctrl, 1);
        clear_stats();
        send_ctrl(16'd4, 16'd1); send_pkt(4'h0, 2); flush(5);
        check(err_no_ctrl, "R8 err sticky", err_no_ctrl, 1);
        check(n_out == 5, "R2 ctrl+video beats", n_out, 5);

        do_reset();
        check(!err_no_ctrl, "R9 err cleared", err_no_ctrl, 0);

        // table of frames: R3 R4 R6 R2 R10
        for (int v = 0; v < NV; v++) begin
            send_ctrl(VEC[v][79:64], VEC[v][63:48]);
            clear_stats();
            send_pkt(4'h0, int'(VEC[v][47:32]));
            flush(30);
            check(n_out == int'(VEC[v][31:16]), "R3/R4/R6 beat count", n_out, VEC[v][31:16]);
            check(n_grey == int'(VEC[v][15:0]), "R4 grey count", n_grey, VEC[v][15:0]);
            check(n_eop == 1, "R10 eop count", n_eop, 1);
            check(eop_idx == n_out - 1, "R10 eop position", eop_idx, n_out - 1);
            check(n_sop == 1, "R10 sop count", n_sop, 1);
            check(bad_ready == 0, "R5 source stalled", bad_ready, 0);
        end

        // R1: foreign type passes whole
        clear_stats();
        send_pkt(4'h3, 3); flush(5);
        check(n_out == 4, "R1 beats", n_out, 4);
        check(last_data == {20'hABCDE, 40'd3}, "R1 data", last_data[39:0], 3);
        check(n_eop == 1 && eop_idx == 3, "R1 eop", eop_idx, 3);

        // R7: zero-size frame
        send_ctrl(16'd0, 16'd5);
        clear_stats();
        send_pkt(4'h0, 3); flush(5);
        check(n_out == 1, "R7 beats", n_out, 1);
        check(eop_idx == 0, "R7 eop on header", eop_idx, 0);

        // R2: control packet ending on its header keeps old size
        send_ctrl(16'd4, 16'd1);
        send(60'hF, 1'b1, 1'b1);
        clear_stats();
        send_pkt(4'h0, 0); flush(10);
        check(n_out == 3, "R2 kept size beats", n_out, 3);
        check(n_grey == 2, "R2 kept size grey", n_grey, 2);

        // R5: grey insertion under downstream back-pressure
        send_ctrl(16'd6, 16'd2);
        clear_stats();
        toggle_ready = 1'b1;
        send_pkt(4'h0, 1); flush(40);
        toggle_ready = 1'b0; out_ready = 1'b1;
        check(n_out == 7, "R5 beats", n_out, 7);
        check(n_grey == 5, "R5 grey", n_grey, 5);
        check(n_eop == 1 && eop_idx == 6, "R5 eop", eop_idx, 6);
        check(bad_ready == 0, "R5 source stalled", bad_ready, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule